// File: doc/BRIEF.md
# Configurable Display Timing Generator

This block produces the raster timing for a parallel display panel. Two counters sweep the frame. The pixel counter runs across a scan line, and the line counter advances once per completed line. Each axis passes through four regions in a fixed order: active, front porch, sync, back porch. The length of every region is programmable.

From the counter positions the block derives three control outputs: horizontal sync, vertical sync and data enable. It also reports the current pixel and line coordinates. Each control output has its own polarity and its own enable. Data enable and the coordinates can be launched on either the rising or the falling clock edge. The two sync outputs can take their own launch edge, or follow the data edge when no separate edge is set.

A double-scan mode repeats every line number on two consecutive lines. Timing parameters are captured only when one frame ends and the next begins. Software may therefore change them at any moment without disturbing the frame in progress.

Top module: `disp_timing_gen`

## Requirements
- R1: The pixel counter `pix_x` runs 0 to HT-1, where HT = HA+HF+HS+HB (active, front porch, sync length, back porch, in pixel clocks). Horizontal sync is asserted for pixels HA+HF up to HA+HF+HS-1. Active comes first, then front porch, then sync, then back porch.
- R2: The line counter advances by one when the pixel counter wraps from HT-1 to 0. It runs 0 to VT-1 with VT = VA+VF+VS+VB, in whole lines and in the same region order. Vertical sync is asserted for whole lines VA+VF up to VA+VF+VS-1.
- R3: Data enable is asserted only when the pixel counter is below HA and the line counter is below VA.
- R4: For each enabled control output, polarity 1 drives 1 while the signal is asserted and 0 otherwise. Polarity 0 inverts that (active low).
- R5: A control output whose enable is 0 is held at 0 and never pulses, whatever its polarity.
- R6: When `cfg_data_edge` is 1, `de`, `pix_x` and `pix_y` change just after the rising clock edge. When it is 0, they change half a cycle later, on the falling edge.
- R7: When `cfg_sync_edge_set` is 1, the sync outputs use `cfg_sync_edge` as their launch edge, with the same 0/1 meaning as in R6. When it is 0, they use `cfg_data_edge`.
- R8: With double scan captured for the frame, `pix_y` reports the line counter divided by 2, rounded down. Every line number therefore appears on two consecutive lines, and the frame length is unchanged.
- R9: The eight timing values and the double-scan flag are captured at reset and at each frame wrap. A change at any other time has no effect until the next frame begins.
- R10: A timing value of 0 is treated as 1.
- R11: While `rst` is high, every output is 0. The first clock after reset is released presents pixel 0 of line 0, so the outputs lag the counters by one clock. Polarity and enable are applied with the values present at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_active | input | H_PW | Active pixels per line |
| cfg_h_front | input | H_PW | Horizontal front porch, in pixels |
| cfg_h_sync | input | H_PW | Horizontal sync length, in pixels |
| cfg_h_back | input | H_PW | Horizontal back porch, in pixels |
| cfg_v_active | input | V_PW | Active lines per frame |
| cfg_v_front | input | V_PW | Vertical front porch, in lines |
| cfg_v_sync | input | V_PW | Vertical sync length, in lines |
| cfg_v_back | input | V_PW | Vertical back porch, in lines |
| cfg_hs_en | input | 1 | Horizontal sync enable |
| cfg_hs_pol | input | 1 | Horizontal sync polarity (1 = high when asserted) |
| cfg_vs_en | input | 1 | Vertical sync enable |
| cfg_vs_pol | input | 1 | Vertical sync polarity |
| cfg_de_en | input | 1 | Data enable output enable |
| cfg_de_pol | input | 1 | Data enable polarity |
| cfg_data_edge | input | 1 | Launch edge for data enable and coordinates (1 = rising, 0 = falling) |
| cfg_sync_edge_set | input | 1 | Use the separate sync launch edge |
| cfg_sync_edge | input | 1 | Launch edge for the sync outputs when the separate edge is selected |
| cfg_dblscan | input | 1 | Double-scan mode |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | H_PW+2 | Pixel counter |
| pix_y | output | V_PW+2 | Line number (halved in double scan) |

## Verification
The tricky coincidence is a software change to the timing values landing in the same cycle as the frame wrap that captures them. A change landing in the middle of the frame is just as tricky, because the frame in progress must keep its old geometry. The bench writes new values part-way through a frame and at random points during random configurations. A reference model captures the values only at its own frame wrap. Every pixel is compared against that model, and the data-enable count of the interrupted frame is checked against the old geometry. The launch-edge behaviour is judged by sampling the outputs twice per clock: once between the rising and the falling edge, and once after the falling edge.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;

    // Region of one axis, in scan order
    typedef enum logic [1:0] {
        RG_ACTIVE,
        RG_FRONT,
        RG_SYNC,
        RG_BACK
    } region_e;

    // The three panel control lines
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } ctl_t;

    // Classify a counter position against the region boundaries
    function automatic region_e region_of(input int unsigned pos,
                                          input int unsigned b_act,
                                          input int unsigned b_ss,
                                          input int unsigned b_se);
        if (pos < b_act)
            return RG_ACTIVE;
        else if (pos < b_ss)
            return RG_FRONT;
        else if (pos < b_se)
            return RG_SYNC;
        return RG_BACK;
    endfunction

    // Output level from the raw asserted state, the enable and the polarity
    function automatic logic launch_level(input logic raw, input logic en, input logic pol);
        return en & ~(raw ^ pol);
    endfunction

endpackage

// File: rtl/tg_axis_shadow.sv
module tg_axis_shadow #(
    parameter int PW = 12,
    parameter int CW = PW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] len_act,
    input  logic [PW-1:0] len_fp,
    input  logic [PW-1:0] len_sync,
    input  logic [PW-1:0] len_bp,
    output logic [CW-1:0] b_act,
    output logic [CW-1:0] b_ss,
    output logic [CW-1:0] b_se,
    output logic [CW-1:0] tot
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] c_act, c_fp, c_sync, c_bp;
    logic [CW-1:0] n_act, n_ss, n_se, n_tot;

    // Zero-length regions are raised to one unit
    always_comb begin
        c_act  = (len_act  == '0) ? ONE : len_act;
        c_fp   = (len_fp   == '0) ? ONE : len_fp;
        c_sync = (len_sync == '0) ? ONE : len_sync;
        c_bp   = (len_bp   == '0) ? ONE : len_bp;
        n_act  = CW'(c_act);
        n_ss   = n_act + CW'(c_fp);
        n_se   = n_ss + CW'(c_sync);
        n_tot  = n_se + CW'(c_bp);
    end

    // Boundaries are captured only at reset or at the frame wrap
    always_ff @(posedge clk) begin
        if (rst || load) begin
            b_act <= n_act;
            b_ss  <= n_ss;
            b_se  <= n_se;
            tot   <= n_tot;
        end
    end

endmodule

// File: rtl/tg_axis_counter.sv
module tg_axis_counter #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [CW-1:0] tot,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = step && (cnt == tot - CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (step)
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/tg_launch.sv
module tg_launch
    import disp_tg_pkg::*;
#(
    parameter int XW = 14,
    parameter int YW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          raw,
    input  ctl_t          en,
    input  ctl_t          pol,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    input  logic          data_edge,
    input  logic          sync_edge,
    output ctl_t          ctl_out,
    output logic [XW-1:0] x_out,
    output logic [YW-1:0] y_out,
    output ctl_t          ctl_q
);
    ctl_t          q_r, q_f;
    logic [XW-1:0] x_r, x_f;
    logic [YW-1:0] y_r, y_f;

    // Rising-edge stage: polarity and enable applied here
    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            x_r <= '0;
            y_r <= '0;
        end else begin
            q_r.de <= launch_level(raw.de, en.de, pol.de);
            q_r.hs <= launch_level(raw.hs, en.hs, pol.hs);
            q_r.vs <= launch_level(raw.vs, en.vs, pol.vs);
            x_r    <= x_in;
            y_r    <= y_in;
        end
    end

    // Falling-edge copy, half a cycle later
    always_ff @(negedge clk) begin
        q_f <= q_r;
        x_f <= x_r;
        y_f <= y_r;
    end

    // Launch edge selection: 1 = rising, 0 = falling
    assign ctl_out.de = data_edge ? q_r.de : q_f.de;
    assign x_out      = data_edge ? x_r : x_f;
    assign y_out      = data_edge ? y_r : y_f;
    assign ctl_out.hs = sync_edge ? q_r.hs : q_f.hs;
    assign ctl_out.vs = sync_edge ? q_r.vs : q_f.vs;
    assign ctl_q      = q_r;

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_tg_pkg::*;
#(
    parameter int H_PW = 12,
    parameter int V_PW = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [H_PW-1:0] cfg_h_active,
    input  logic [H_PW-1:0] cfg_h_front,
    input  logic [H_PW-1:0] cfg_h_sync,
    input  logic [H_PW-1:0] cfg_h_back,
    input  logic [V_PW-1:0] cfg_v_active,
    input  logic [V_PW-1:0] cfg_v_front,
    input  logic [V_PW-1:0] cfg_v_sync,
    input  logic [V_PW-1:0] cfg_v_back,
    input  logic            cfg_hs_en,
    input  logic            cfg_hs_pol,
    input  logic            cfg_vs_en,
    input  logic            cfg_vs_pol,
    input  logic            cfg_de_en,
    input  logic            cfg_de_pol,
    input  logic            cfg_data_edge,
    input  logic            cfg_sync_edge_set,
    input  logic            cfg_sync_edge,
    input  logic            cfg_dblscan,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [H_PW+1:0] pix_x,
    output logic [V_PW+1:0] pix_y
);
    localparam int H_CW = H_PW + 2;
    localparam int V_CW = V_PW + 2;

    logic [H_CW-1:0] h_cnt, hb_act, hb_ss, hb_se, h_tot;
    logic [V_CW-1:0] v_cnt, vb_act, vb_ss, vb_se, v_tot;
    logic            h_wrap, v_wrap, frame_end, dbl_q, sync_edge_eff;
    region_e         h_rg, v_rg;
    ctl_t            raw, en_v, pol_v, ctl_o, ctl_q;
    logic [V_CW-1:0] y_src;

    // Frame ends when the line counter wraps (only on a pixel wrap)
    assign frame_end = v_wrap;

    tg_axis_shadow #(.PW(H_PW), .CW(H_CW)) u_h_shadow (
        .clk(clk), .rst(rst), .load(frame_end),
        .len_act(cfg_h_active), .len_fp(cfg_h_front),
        .len_sync(cfg_h_sync), .len_bp(cfg_h_back),
        .b_act(hb_act), .b_ss(hb_ss), .b_se(hb_se), .tot(h_tot)
    );

    tg_axis_shadow #(.PW(V_PW), .CW(V_CW)) u_v_shadow (
        .clk(clk), .rst(rst), .load(frame_end),
        .len_act(cfg_v_active), .len_fp(cfg_v_front),
        .len_sync(cfg_v_sync), .len_bp(cfg_v_back),
        .b_act(vb_act), .b_ss(vb_ss), .b_se(vb_se), .tot(v_tot)
    );

    always_ff @(posedge clk) begin
        if (rst || frame_end)
            dbl_q <= cfg_dblscan;
    end

    tg_axis_counter #(.CW(H_CW)) u_h_cnt (
        .clk(clk), .rst(rst), .step(1'b1), .tot(h_tot),
        .cnt(h_cnt), .wrap(h_wrap)
    );

    tg_axis_counter #(.CW(V_CW)) u_v_cnt (
        .clk(clk), .rst(rst), .step(h_wrap), .tot(v_tot),
        .cnt(v_cnt), .wrap(v_wrap)
    );

    always_comb begin
        h_rg   = region_of(32'(h_cnt), 32'(hb_act), 32'(hb_ss), 32'(hb_se));
        v_rg   = region_of(32'(v_cnt), 32'(vb_act), 32'(vb_ss), 32'(vb_se));
        raw.de = (h_rg == RG_ACTIVE) && (v_rg == RG_ACTIVE);
        raw.hs = (h_rg == RG_SYNC);
        raw.vs = (v_rg == RG_SYNC);
        y_src  = dbl_q ? (v_cnt >> 1) : v_cnt;
    end

    assign en_v          = '{de: cfg_de_en,  hs: cfg_hs_en,  vs: cfg_vs_en};
    assign pol_v         = '{de: cfg_de_pol, hs: cfg_hs_pol, vs: cfg_vs_pol};
    assign sync_edge_eff = cfg_sync_edge_set ? cfg_sync_edge : cfg_data_edge;

    tg_launch #(.XW(H_CW), .YW(V_CW)) u_launch (
        .clk(clk), .rst(rst), .raw(raw), .en(en_v), .pol(pol_v),
        .x_in(h_cnt), .y_in(y_src),
        .data_edge(cfg_data_edge), .sync_edge(sync_edge_eff),
        .ctl_out(ctl_o), .x_out(pix_x), .y_out(pix_y), .ctl_q(ctl_q)
    );

    assign de    = ctl_o.de;
    assign hsync = ctl_o.hs;
    assign vsync = ctl_o.vs;

endmodule

// File: rtl/disp_tg_checker.sv
module disp_tg_checker
    import disp_tg_pkg::*;
#(
    parameter int H_CW = 14,
    parameter int V_CW = 13
) (
    input logic            clk,
    input logic            rst,
    input logic [H_CW-1:0] h_cnt,
    input logic [H_CW-1:0] h_tot,
    input logic [H_CW-1:0] hb_act,
    input logic [H_CW-1:0] hb_ss,
    input logic [H_CW-1:0] hb_se,
    input logic [V_CW-1:0] v_cnt,
    input logic [V_CW-1:0] v_tot,
    input logic [V_CW-1:0] vb_act,
    input logic            cfg_de_en,
    input logic            cfg_de_pol,
    input logic            cfg_hs_en,
    input logic            cfg_hs_pol,
    input ctl_t            ctl_q
);
    logic h_last, f_last;
    assign h_last = (h_cnt == h_tot - H_CW'(1));
    assign f_last = h_last && (v_cnt == v_tot - V_CW'(1));

    AST_H_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> (h_cnt == $past(h_cnt) + H_CW'(1))); // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        h_last |=> (h_cnt == '0)); // R1
    AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
        !h_last |=> $stable(v_cnt)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        f_last |=> (v_cnt == '0 && h_cnt == '0)); // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !f_last |=> ($stable(h_tot) && $stable(hb_act) && $stable(v_tot) && $stable(vb_act))); // R9
    AST_CLAMP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (hb_act != '0) && (hb_ss > hb_act) && (hb_se > hb_ss) && (h_tot > hb_se)); // R10
    AST_DE_H_BLANK: assert property (@(posedge clk) disable iff (rst)
        (cfg_de_en && cfg_de_pol && h_cnt >= hb_act) |=> !ctl_q.de); // R3
    AST_DE_V_BLANK: assert property (@(posedge clk) disable iff (rst)
        (cfg_de_en && cfg_de_pol && v_cnt >= vb_act) |=> !ctl_q.de); // R3
    AST_HS_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_hs_en && !cfg_hs_pol && h_cnt < hb_ss) |=> ctl_q.hs); // R4
    AST_DE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_de_en |=> !ctl_q.de); // R5
    AST_HS_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_hs_en |=> !ctl_q.hs); // R5

endmodule

bind disp_timing_gen disp_tg_checker #(.H_CW(H_PW + 2), .V_CW(V_PW + 2)) u_chk (
    .clk(clk), .rst(rst),
    .h_cnt(h_cnt), .h_tot(h_tot), .hb_act(hb_act), .hb_ss(hb_ss), .hb_se(hb_se),
    .v_cnt(v_cnt), .v_tot(v_tot), .vb_act(vb_act),
    .cfg_de_en(cfg_de_en), .cfg_de_pol(cfg_de_pol),
    .cfg_hs_en(cfg_hs_en), .cfg_hs_pol(cfg_hs_pol),
    .ctl_q(ctl_q)
);

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;
    localparam int H_PW = 12;
    localparam int V_PW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [H_PW-1:0] cfg_h_active, cfg_h_front, cfg_h_sync, cfg_h_back;
    logic [V_PW-1:0] cfg_v_active, cfg_v_front, cfg_v_sync, cfg_v_back;
    logic cfg_hs_en, cfg_hs_pol, cfg_vs_en, cfg_vs_pol, cfg_de_en, cfg_de_pol;
    logic cfg_data_edge, cfg_sync_edge_set, cfg_sync_edge, cfg_dblscan;
    logic hsync, vsync, de;
    logic [H_PW+1:0] pix_x;
    logic [V_PW+1:0] pix_y;

    always #2.5 clk = ~clk;

    disp_timing_gen #(.H_PW(H_PW), .V_PW(V_PW)) i_disp_timing_gen (
        .clk(clk), .rst(rst),
        .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
        .cfg_v_active(cfg_v_active), .cfg_v_front(cfg_v_front),
        .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back),
        .cfg_hs_en(cfg_hs_en), .cfg_hs_pol(cfg_hs_pol),
        .cfg_vs_en(cfg_vs_en), .cfg_vs_pol(cfg_vs_pol),
        .cfg_de_en(cfg_de_en), .cfg_de_pol(cfg_de_pol),
        .cfg_data_edge(cfg_data_edge), .cfg_sync_edge_set(cfg_sync_edge_set),
        .cfg_sync_edge(cfg_sync_edge), .cfg_dblscan(cfg_dblscan),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string ctx     = "R11";
    int    de_hits = 0;

    // Reference model state
    typedef struct {
        int de;
        int hs;
        int vs;
        int x;
        int y;
    } st_t;

    int  sh_ha, sh_hf, sh_hs, sh_hb, sh_va, sh_vf, sh_vs, sh_vb, sh_dbl;
    int  mh, mv, loads;
    st_t cur, prv;

    function automatic int c1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int lvl(input int raw, input int en, input int pol);
        return (en != 0 && raw == pol) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, ctx, $time, act, exp);
        end
    endtask

    task automatic load_shadow();
        sh_ha  = c1(int'(cfg_h_active));
        sh_hf  = c1(int'(cfg_h_front));
        sh_hs  = c1(int'(cfg_h_sync));
        sh_hb  = c1(int'(cfg_h_back));
        sh_va  = c1(int'(cfg_v_active));
        sh_vf  = c1(int'(cfg_v_front));
        sh_vs  = c1(int'(cfg_v_sync));
        sh_vb  = c1(int'(cfg_v_back));
        sh_dbl = int'(cfg_dblscan);
        loads++;
    endtask

    task automatic model_edge();
        int ht, vt, da, hr, vr;
        prv = cur;
        da = (mh < sh_ha && mv < sh_va) ? 1 : 0;
        hr = (mh >= sh_ha + sh_hf && mh < sh_ha + sh_hf + sh_hs) ? 1 : 0;
        vr = (mv >= sh_va + sh_vf && mv < sh_va + sh_vf + sh_vs) ? 1 : 0;
        cur.de = lvl(da, int'(cfg_de_en), int'(cfg_de_pol));
        cur.hs = lvl(hr, int'(cfg_hs_en), int'(cfg_hs_pol));
        cur.vs = lvl(vr, int'(cfg_vs_en), int'(cfg_vs_pol));
        cur.x  = mh;
        cur.y  = (sh_dbl != 0) ? mv / 2 : mv;
        ht = sh_ha + sh_hf + sh_hs + sh_hb;
        vt = sh_va + sh_vf + sh_vs + sh_vb;
        if (mh == ht - 1) begin
            mh = 0;
            if (mv == vt - 1) begin
                mv = 0;
                load_shadow();
            end else begin
                mv++;
            end
        end else begin
            mh++;
        end
    endtask

    // One clock: early sample between rising and falling edge, late sample after falling edge
    task automatic step();
        int de_e, sy_e;
        @(posedge clk);
        model_edge();
        #1;
        de_e = int'(cfg_data_edge);
        sy_e = (cfg_sync_edge_set == 1'b1) ? int'(cfg_sync_edge) : int'(cfg_data_edge);
        chk("R6", int'(de),    (de_e != 0) ? cur.de : prv.de);
        chk("R6", int'(pix_x), (de_e != 0) ? cur.x  : prv.x);
        chk("R6", int'(pix_y), (de_e != 0) ? cur.y  : prv.y);
        chk("R7", int'(hsync), (sy_e != 0) ? cur.hs : prv.hs);
        chk("R7", int'(vsync), (sy_e != 0) ? cur.vs : prv.vs);
        #2.5;
        chk("R3", int'(de),    cur.de);
        chk("R1", int'(pix_x), cur.x);
        chk("R2", int'(pix_y), cur.y);
        chk((cfg_hs_en == 1'b1) ? "R4" : "R5", int'(hsync), cur.hs);
        chk((cfg_vs_en == 1'b1) ? "R4" : "R5", int'(vsync), cur.vs);
        if (de == 1'b1) de_hits++;
    endtask

    task automatic run_frames(input int n);
        int target;
        target = loads + n;
        while (loads < target) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #3.5;
            chk("R11", int'(de), 0);
            chk("R11", int'(hsync), 0);
            chk("R11", int'(vsync), 0);
            chk("R11", int'(pix_x), 0);
            chk("R11", int'(pix_y), 0);
        end
        mh = 0;
        mv = 0;
        loads = 0;
        load_shadow();
        cur = '{default: 0};
        prv = cur;
        rst = 1'b0;
    endtask

    task automatic set_h(input int a, input int f, input int s, input int b);
        cfg_h_active = H_PW'(a);
        cfg_h_front  = H_PW'(f);
        cfg_h_sync   = H_PW'(s);
        cfg_h_back   = H_PW'(b);
    endtask

    task automatic set_v(input int a, input int f, input int s, input int b);
        cfg_v_active = V_PW'(a);
        cfg_v_front  = V_PW'(f);
        cfg_v_sync   = V_PW'(s);
        cfg_v_back   = V_PW'(b);
    endtask

    task automatic set_ctl(input bit en, input bit pol);
        cfg_hs_en = en; cfg_hs_pol = pol;
        cfg_vs_en = en; cfg_vs_pol = pol;
        cfg_de_en = en; cfg_de_pol = pol;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired [%s]", ctx);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        set_h(4, 2, 3, 2);
        set_v(3, 1, 2, 1);
        set_ctl(1'b1, 1'b1);
        cfg_data_edge = 1'b1; cfg_sync_edge_set = 1'b0; cfg_sync_edge = 1'b0;
        cfg_dblscan = 1'b0;

        // R11: reset state and first pixel after release
        ctx = "R11";
        do_reset();
        step();
        chk("R11", int'(pix_x), 0);
        chk("R11", int'(de), 1);
        ctx = "R1";
        run_frames(2);

        // R10: all-zero parameters behave as 1 each: 16-pixel frame, one enabled pixel
        ctx = "R10";
        set_h(0, 0, 0, 0);
        set_v(0, 0, 0, 0);
        run_frames(1);
        de_hits = 0;
        run_frames(1);
        chk("R10", de_hits, 1);
        run_frames(1);

        // R9: change parameters mid-frame; the running frame keeps its geometry
        ctx = "R9";
        set_h(5, 1, 2, 1);
        set_v(4, 1, 1, 1);
        run_frames(1);
        de_hits = 0;
        repeat (7) step();
        set_h(2, 3, 1, 1);
        set_v(2, 2, 2, 2);
        run_frames(1);
        chk("R9", de_hits, 20);
        de_hits = 0;
        run_frames(1);
        chk("R9", de_hits, 4);

        // R8: double scan
        ctx = "R8";
        cfg_dblscan = 1'b1;
        set_v(6, 1, 1, 2);
        run_frames(2);
        cfg_dblscan = 1'b0;
        run_frames(1);

        // R7: separate sync edge and fallback to data edge
        ctx = "R7";
        cfg_data_edge = 1'b1; cfg_sync_edge_set = 1'b1; cfg_sync_edge = 1'b0;
        run_frames(1);
        cfg_data_edge = 1'b0; cfg_sync_edge_set = 1'b0; cfg_sync_edge = 1'b1;
        run_frames(1);
        cfg_data_edge = 1'b0; cfg_sync_edge_set = 1'b1; cfg_sync_edge = 1'b1;
        run_frames(1);

        // R4 / R5: active-low and disabled outputs
        ctx = "R4";
        set_ctl(1'b1, 1'b0);
        run_frames(1);
        ctx = "R5";
        set_ctl(1'b0, 1'b1);
        run_frames(1);

        // Random configurations with live control changes
        ctx = "R1";
        for (int it = 0; it < 30; it++) begin
            set_h($urandom_range(6, 0), $urandom_range(6, 0), $urandom_range(6, 0), $urandom_range(6, 0));
            set_v($urandom_range(6, 0), $urandom_range(6, 0), $urandom_range(6, 0), $urandom_range(6, 0));
            cfg_hs_en = ($urandom_range(3, 0) != 0); cfg_hs_pol = 1'($urandom_range(1, 0));
            cfg_vs_en = ($urandom_range(3, 0) != 0); cfg_vs_pol = 1'($urandom_range(1, 0));
            cfg_de_en = ($urandom_range(3, 0) != 0); cfg_de_pol = 1'($urandom_range(1, 0));
            cfg_data_edge     = 1'($urandom_range(1, 0));
            cfg_sync_edge_set = 1'($urandom_range(1, 0));
            cfg_sync_edge     = 1'($urandom_range(1, 0));
            cfg_dblscan       = 1'($urandom_range(1, 0));
            repeat ($urandom_range(40, 1)) step();
            cfg_hs_pol = ~cfg_hs_pol;
            cfg_data_edge = 1'($urandom_range(1, 0));
            run_frames(2);
        end

        summary();
        $finish;
    end

endmodule